// File: doc/BRIEF.md
# Filtered Event Counter Group

This block holds a small set of event counters reached through a plain memory-mapped register port. Each counter picks one per-cycle event pulse by code. It can be limited to traffic whose stream identifier equals a programmed value, or falls inside a wildcard range taken from that value. Software arms counters, arms their interrupts and handles their overflow flags through paired set and clear bit-vector registers. It loads and reads counter values, and discovers the geometry and the supported events from read-only capability registers.

The register port is a single-cycle one. A write with `wr_en` high takes effect at the next rising clock edge. Read data is a combinational function of `addr` and the current state. One level-sensitive interrupt goes high while any counter has both its overflow flag and its interrupt enable set and the global interrupt enable is on.

Top module: `efc_group`

## Requirements
- R1: After reset, every counter, every enable vector, the overflow vector, the global count enable (bit 0 at 0xE04) and the global interrupt enable (bit 0 at 0xE50) are zero, and `irq` is low.
- R2: Counter n (at byte offset n*4 while counters are 32 bits or narrower, n*8 otherwise) increases by exactly one on a clock edge when the global count enable is 1, its enable bit is 1, its selected event pulse is high and the stream filter accepts `evt_sid`.
- R3: Event code 0 counts every clock edge and ignores both the pulse inputs and the stream filter. Codes at or above the number of pulse inputs never count.
- R4: With the span bit (bit 29 of the event-type register at 0x400 + 4n, code in bits [15:0]) cleared, the counter counts only when `evt_sid` equals the match register at 0xA00 + 4n.
- R5: With the span bit set, the match register's bits from its lowest zero bit downward are ignored and only the bits above must equal `evt_sid`. A match value of all ones accepts every identifier.
- R6: Counter enables are set by writing ones to 0xC00 and cleared by writing ones to 0xC20. Interrupt enables use 0xC40 and 0xC60 in the same way. Both addresses of a pair read the current vector. A counter whose enable bit is 0 holds its value.
- R7: A counter that steps from all ones to zero sets its overflow bit. Overflow bits read at 0xC80 and 0xCC0, are cleared by ones written to 0xC80, are set by ones written to 0xCC0, and otherwise stay set.
- R8: `irq` is high exactly while the global interrupt enable is 1 and overflow AND interrupt-enable is nonzero.
- R9: A software write to a counter in the cycle it would count stores the written value, with no increment and no overflow.
- R10: 0xE00 reads counters-minus-one in [5:0], counter-width-minus-one in [13:8], 1 in bit 23 and 0 elsewhere. 0xE20 reads a bitmap with one bit set for each pulse input, and 0xE28 reads 0.
- R11: Bit 30 of the event-type register is reserved: it is not stored and reads 0.
- R12: While the global count enable is 0, no counter changes except by a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for reads and writes |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data for `addr` |
| evt_pulse | input | NUM_EVT | Per-cycle event pulses, indexed by event code |
| evt_sid | input | SID_W | Stream identifier of this cycle's events |
| irq | output | 1 | Level interrupt |

## Verification
Every effect in this block is due one clock edge after its cause. A write, a pulse or a wrap registers at the next rising edge. After that edge, `rdata` shows the new state without further delay, and so does `irq`. The bench drives inputs at falling edges and keeps a behavioural model that advances on the same rising edge. It compares `irq` at every falling edge. It samples `rdata` just after the falling edge that follows the edge under test. The counter write that races an increment is therefore read back before the following edge can add one to it.

// File: rtl/efc_pkg.sv
package efc_pkg;
    localparam int OFS_TYPE     = 'h400;
    localparam int OFS_MATCH    = 'hA00;
    localparam int OFS_CEN_SET  = 'hC00;
    localparam int OFS_CEN_CLR  = 'hC20;
    localparam int OFS_IEN_SET  = 'hC40;
    localparam int OFS_IEN_CLR  = 'hC60;
    localparam int OFS_OVF_CLR  = 'hC80;
    localparam int OFS_OVF_SET  = 'hCC0;
    localparam int OFS_CFG      = 'hE00;
    localparam int OFS_CTRL     = 'hE04;
    localparam int OFS_EVMAP_LO = 'hE20;
    localparam int OFS_EVMAP_HI = 'hE28;
    localparam int OFS_IRQCTL   = 'hE50;
    localparam int CODE_W       = 16;
    localparam int SPAN_BIT     = 29;
    localparam int CFG_FILT_BIT = 23;
endpackage

// File: rtl/efc_sid_match.sv
module efc_sid_match #(
    parameter int SID_W = 32
) (
    input  logic [SID_W-1:0] sid,
    input  logic [SID_W-1:0] pattern,
    input  logic             span,
    output logic             hit
);
    // trailing ones plus the lowest zero: the wildcard field in span mode
    logic [SID_W-1:0] dont_care;
    assign dont_care = pattern ^ (pattern + SID_W'(1));
    assign hit = span ? (((sid ^ pattern) & ~dont_care) == '0)
                      : (sid == pattern);
endmodule

// File: rtl/efc_read_mux.sv
module efc_read_mux
    import efc_pkg::*;
#(
    parameter int N       = 4,
    parameter int CTR_W   = 32,
    parameter int SID_W   = 32,
    parameter int NUM_EVT = 8,
    parameter int ADDR_W  = 12
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [N-1:0][CTR_W-1:0]      cnt,
    input  logic [N-1:0][CODE_W-1:0]     code,
    input  logic [N-1:0]                 span,
    input  logic [N-1:0][SID_W-1:0]      pat,
    input  logic [N-1:0]                 cen,
    input  logic [N-1:0]                 ien,
    input  logic [N-1:0]                 ovf,
    input  logic                         gen,
    input  logic                         gie,
    output logic [63:0]                  rdata
);
    localparam int STRIDE = (CTR_W > 32) ? 8 : 4;

    logic [63:0] cfg_word;
    logic [63:0] evmap;

    assign cfg_word = {40'd0, 1'b1, 9'd0, 6'(CTR_W - 1), 2'd0, 6'(N - 1)};

    always_comb begin
        evmap = '0;
        evmap[NUM_EVT-1:0] = '1;
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < N; n++) begin
            if (addr == ADDR_W'(n * STRIDE))
                rdata = 64'(cnt[n]);
            if (addr == ADDR_W'(OFS_TYPE + 4 * n))
                rdata = {34'd0, span[n], 13'd0, code[n]};
            if (addr == ADDR_W'(OFS_MATCH + 4 * n))
                rdata = 64'(pat[n]);
        end
        if (addr == ADDR_W'(OFS_CEN_SET) || addr == ADDR_W'(OFS_CEN_CLR)) rdata = 64'(cen);
        if (addr == ADDR_W'(OFS_IEN_SET) || addr == ADDR_W'(OFS_IEN_CLR)) rdata = 64'(ien);
        if (addr == ADDR_W'(OFS_OVF_SET) || addr == ADDR_W'(OFS_OVF_CLR)) rdata = 64'(ovf);
        if (addr == ADDR_W'(OFS_CFG))      rdata = cfg_word;
        if (addr == ADDR_W'(OFS_CTRL))     rdata = {63'd0, gen};
        if (addr == ADDR_W'(OFS_IRQCTL))   rdata = {63'd0, gie};
        if (addr == ADDR_W'(OFS_EVMAP_LO)) rdata = evmap;
        if (addr == ADDR_W'(OFS_EVMAP_HI)) rdata = '0;
    end
endmodule

// File: rtl/efc_group.sv
module efc_group
    import efc_pkg::*;
#(
    parameter int N       = 4,
    parameter int CTR_W   = 32,
    parameter int SID_W   = 32,
    parameter int NUM_EVT = 8,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [63:0]        wdata,
    output logic [63:0]        rdata,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [SID_W-1:0]   evt_sid,
    output logic               irq
);
    localparam int STRIDE = (CTR_W > 32) ? 8 : 4;
    localparam int EV_IW  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    typedef struct packed {
        logic [N-1:0][CTR_W-1:0]  cnt;
        logic [N-1:0][CODE_W-1:0] code;
        logic [N-1:0]             span;
        logic [N-1:0][SID_W-1:0]  pat;
        logic [N-1:0]             cen;
        logic [N-1:0]             ien;
        logic [N-1:0]             ovf;
        logic                     gen;
        logic                     gie;
    } efc_state_t;

    efc_state_t st_d, st_q;

    logic [N-1:0] hit_cnt, hit_type, hit_pat, sid_ok, fire;
    logic [N-1:0] wvec;
    logic         unused_wdata;

    // views of the state for the read mux and the bound checker
    logic [N-1:0][CTR_W-1:0] cnt_q;
    logic [N-1:0]            cen_q, ien_q, ovf_q;
    logic                    gen_q, gie_q;

    assign cnt_q = st_q.cnt;
    assign cen_q = st_q.cen;
    assign ien_q = st_q.ien;
    assign ovf_q = st_q.ovf;
    assign gen_q = st_q.gen;
    assign gie_q = st_q.gie;

    assign wvec         = wdata[N-1:0];
    assign unused_wdata = ^wdata;

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign hit_cnt[g]  = wr_en && (addr == ADDR_W'(g * STRIDE));
        assign hit_type[g] = wr_en && (addr == ADDR_W'(OFS_TYPE + 4 * g));
        assign hit_pat[g]  = wr_en && (addr == ADDR_W'(OFS_MATCH + 4 * g));

        efc_sid_match #(.SID_W(SID_W)) u_match (
            .sid     (evt_sid),
            .pattern (st_q.pat[g]),
            .span    (st_q.span[g]),
            .hit     (sid_ok[g])
        );

        assign fire[g] = (st_q.code[g] == '0) ? 1'b1
                       : ((st_q.code[g] < CODE_W'(NUM_EVT))
                          && evt_pulse[st_q.code[g][EV_IW-1:0]]
                          && sid_ok[g]);
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == ADDR_W'(OFS_CEN_SET)) st_d.cen = st_q.cen | wvec;
            if (addr == ADDR_W'(OFS_CEN_CLR)) st_d.cen = st_q.cen & ~wvec;
            if (addr == ADDR_W'(OFS_IEN_SET)) st_d.ien = st_q.ien | wvec;
            if (addr == ADDR_W'(OFS_IEN_CLR)) st_d.ien = st_q.ien & ~wvec;
            if (addr == ADDR_W'(OFS_OVF_SET)) st_d.ovf = st_q.ovf | wvec;
            if (addr == ADDR_W'(OFS_OVF_CLR)) st_d.ovf = st_q.ovf & ~wvec;
            if (addr == ADDR_W'(OFS_CTRL))    st_d.gen = wdata[0];
            if (addr == ADDR_W'(OFS_IRQCTL))  st_d.gie = wdata[0];
        end
        for (int n = 0; n < N; n++) begin
            if (hit_type[n]) begin
                st_d.code[n] = wdata[CODE_W-1:0];
                st_d.span[n] = wdata[SPAN_BIT];
            end
            if (hit_pat[n])
                st_d.pat[n] = wdata[SID_W-1:0];
            if (hit_cnt[n]) begin
                st_d.cnt[n] = wdata[CTR_W-1:0];
            end else if (st_q.gen && st_q.cen[n] && fire[n]) begin
                st_d.cnt[n] = st_q.cnt[n] + CTR_W'(1);
                if (&st_q.cnt[n])
                    st_d.ovf[n] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.gie && (|(st_q.ovf & st_q.ien));

    efc_read_mux #(
        .N(N), .CTR_W(CTR_W), .SID_W(SID_W), .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)
    ) u_rd (
        .addr  (addr),
        .cnt   (cnt_q),
        .code  (st_q.code),
        .span  (st_q.span),
        .pat   (st_q.pat),
        .cen   (cen_q),
        .ien   (ien_q),
        .ovf   (ovf_q),
        .gen   (gen_q),
        .gie   (gie_q),
        .rdata (rdata)
    );
endmodule

// File: rtl/efc_group_chk.sv
module efc_group_chk #(
    parameter int N     = 4,
    parameter int CTR_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [N-1:0][CTR_W-1:0] cnt,
    input logic [N-1:0]            cen,
    input logic [N-1:0]            ien,
    input logic [N-1:0]            ovf,
    input logic                    gen,
    input logic                    gie,
    input logic                    irq
);
    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && ((ovf & ien) != '0)));

    a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (gie && ((ovf & ien) != '0)) |-> irq);

    a_r12_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !gen) |=> $stable(cnt));

    for (genvar g = 0; g < N; g++) begin : g_ctr
        a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> (cnt[g] == $past(cnt[g]) || cnt[g] == $past(cnt[g]) + CTR_W'(1)));

        a_r6_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && !cen[g]) |=> $stable(cnt[g]));

        a_r7_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && (&cnt[g])) |=> (cnt[g] != '0 || ovf[g]));

        a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && ovf[g]) |=> ovf[g]);
    end
endmodule

bind efc_group efc_group_chk #(.N(N), .CTR_W(CTR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .cnt   (cnt_q),
    .cen   (cen_q),
    .ien   (ien_q),
    .ovf   (ovf_q),
    .gen   (gen_q),
    .gie   (gie_q),
    .irq   (irq)
);

// File: tb/efc_group_test.sv
module efc_group_test;
    localparam int PERIOD = 10;
    localparam int NC     = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic [7:0]  evt_pulse = '0;
    logic [31:0] evt_sid = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(PERIOD / 2) clk = ~clk;

    efc_group uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .evt_pulse(evt_pulse), .evt_sid(evt_sid), .irq(irq)
    );

    // behavioural reference model
    logic [31:0] m_cnt  [NC];
    logic [15:0] m_code [NC];
    logic        m_span [NC];
    logic [31:0] m_pat  [NC];
    logic [NC-1:0] m_cen, m_ien, m_ovf, m_inc;
    logic        m_gen, m_gie;

    function automatic bit m_sid_ok(int n, logic [31:0] sid);
        if (!m_span[n]) return sid == m_pat[n];
        for (int b = 0; b < 32; b++) begin
            if (!m_pat[n][b]) begin
                for (int k = b + 1; k < 32; k++)
                    if (sid[k] != m_pat[n][k]) return 0;
                return 1;
            end
        end
        return 1;
    endfunction

    function automatic logic [63:0] m_read(logic [11:0] a);
        for (int n = 0; n < NC; n++) begin
            if (a == 12'(n * 4))          return {32'd0, m_cnt[n]};
            if (a == 12'('h400 + 4 * n))  return {34'd0, m_span[n], 13'd0, m_code[n]};
            if (a == 12'('hA00 + 4 * n))  return {32'd0, m_pat[n]};
        end
        case (a)
            12'hC00, 12'hC20: return {60'd0, m_cen};
            12'hC40, 12'hC60: return {60'd0, m_ien};
            12'hC80, 12'hCC0: return {60'd0, m_ovf};
            12'hE04:          return {63'd0, m_gen};
            12'hE50:          return {63'd0, m_gie};
            12'hE00:          return 64'h0080_1F03;
            12'hE20:          return 64'hFF;
            default:          return 64'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < NC; n++) begin
                m_cnt[n] = '0; m_code[n] = '0; m_span[n] = 1'b0; m_pat[n] = '0;
            end
            m_cen = '0; m_ien = '0; m_ovf = '0; m_gen = 1'b0; m_gie = 1'b0;
        end else begin
            for (int n = 0; n < NC; n++) begin
                bit f;
                if (m_code[n] == 0)      f = 1;
                else if (m_code[n] < 8)  f = evt_pulse[m_code[n]] && m_sid_ok(n, evt_sid);
                else                     f = 0;
                m_inc[n] = m_gen && m_cen[n] && f;
            end
            if (wr_en) begin
                case (addr)
                    12'hC00: m_cen = m_cen | wdata[NC-1:0];
                    12'hC20: m_cen = m_cen & ~wdata[NC-1:0];
                    12'hC40: m_ien = m_ien | wdata[NC-1:0];
                    12'hC60: m_ien = m_ien & ~wdata[NC-1:0];
                    12'hCC0: m_ovf = m_ovf | wdata[NC-1:0];
                    12'hC80: m_ovf = m_ovf & ~wdata[NC-1:0];
                    12'hE04: m_gen = wdata[0];
                    12'hE50: m_gie = wdata[0];
                    default: ;
                endcase
                for (int n = 0; n < NC; n++) begin
                    if (addr == 12'(n * 4)) begin m_cnt[n] = wdata[31:0]; m_inc[n] = 1'b0; end
                    if (addr == 12'('h400 + 4 * n)) begin m_code[n] = wdata[15:0]; m_span[n] = wdata[29]; end
                    if (addr == 12'('hA00 + 4 * n)) m_pat[n] = wdata[31:0];
                end
            end
            for (int n = 0; n < NC; n++) begin
                if (m_inc[n]) begin
                    if (m_cnt[n] == 32'hFFFF_FFFF) m_ovf[n] = 1'b1;
                    m_cnt[n] = m_cnt[n] + 32'd1;
                end
            end
        end
    end

    // R8: interrupt compared with the model at every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic exp_irq;
            exp_irq = m_gie && ((m_ovf & m_ien) != '0);
            checks++;
            if (irq !== exp_irq) begin
                errors++;
                $display("FAIL R8 irq actual %0b expected %0b at %0t", irq, exp_irq, $time);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m, input logic [31:0] s);
        @(negedge clk);
        evt_pulse = m; evt_sid = s;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic chk_model(input logic [11:0] a, input string req);
        logic [63:0] e;
        addr = a; #1;
        e = m_read(a);
        checks++;
        if (rdata !== e) begin
            errors++;
            $display("FAIL %s addr %h actual %h expected %h", req, a, rdata, e);
        end
    endtask

    task automatic chk_val(input logic [11:0] a, input logic [63:0] e, input string req);
        addr = a; #1;
        checks++;
        if (rdata !== e) begin
            errors++;
            $display("FAIL %s addr %h actual %h expected %h", req, a, rdata, e);
        end
    endtask

    task automatic chk_irq(input logic e, input string req);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", req, irq, e);
        end
    endtask

    initial begin
        #(PERIOD * 50000);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_val(12'h000, 64'd0, "R1");
        chk_val(12'hC00, 64'd0, "R1");
        chk_val(12'hCC0, 64'd0, "R1");
        chk_val(12'hE04, 64'd0, "R1");
        chk_irq(1'b0, "R1");
        // R10 capability words
        chk_val(12'hE00, 64'h0080_1F03, "R10");
        chk_val(12'hE20, 64'hFF, "R10");
        chk_val(12'hE28, 64'd0, "R10");

        // program: c0 exact 0x42 on event 1, c1 span 0x43 on event 1,
        // c2 cycles, c3 span all-ones on event 2 with reserved bit 30 written
        wr(12'h400, 64'h1);
        wr(12'hA00, 64'h42);
        wr(12'h404, 64'h2000_0001);
        wr(12'hA04, 64'h43);
        wr(12'h408, 64'h0);
        wr(12'h40C, 64'h6000_0002);
        wr(12'hA0C, 64'hFFFF_FFFF);
        chk_val(12'h40C, 64'h2000_0002, "R11");
        wr(12'hC00, 64'hF);
        wr(12'hE04, 64'h1);

        pulse(8'h06, 32'h42);
        pulse(8'h02, 32'h45);
        pulse(8'h02, 32'h48);
        pulse(8'h06, 32'h40);
        pulse(8'h04, 32'h1234);
        pulse(8'h02, 32'h43);
        chk_val(12'h000, 64'd1, "R4");
        chk_val(12'h004, 64'd4, "R5");
        chk_val(12'h00C, 64'd3, "R5");
        chk_model(12'h008, "R3");
        chk_model(12'h000, "R2");

        // R12 global enable off
        wr(12'hE04, 64'h0);
        chk_model(12'h008, "R12");
        pulse(8'h06, 32'h42);
        chk_val(12'h000, 64'd1, "R12");
        chk_model(12'h008, "R12");

        // R6 enable vectors
        wr(12'hC20, 64'h1);
        chk_val(12'hC00, 64'hE, "R6");
        wr(12'hE04, 64'h1);
        pulse(8'h02, 32'h42);
        chk_val(12'h000, 64'd1, "R6");
        wr(12'hC40, 64'h5);
        chk_val(12'hC60, 64'h5, "R6");
        wr(12'hC60, 64'h4);
        chk_val(12'hC40, 64'h1, "R6");

        // R7 wrap and overflow vector, R8 interrupt
        wr(12'hC00, 64'h1);
        wr(12'h000, 64'hFFFF_FFFE);
        pulse(8'h02, 32'h42);
        chk_val(12'hCC0, 64'h0, "R7");
        pulse(8'h02, 32'h42);
        chk_val(12'h000, 64'd0, "R7");
        chk_val(12'hCC0, 64'h1, "R7");
        chk_irq(1'b0, "R8");
        wr(12'hE50, 64'h1);
        chk_irq(1'b1, "R8");
        wr(12'hC80, 64'h1);
        chk_val(12'hC80, 64'h0, "R7");
        chk_irq(1'b0, "R8");
        wr(12'hCC0, 64'h8);
        chk_val(12'hCC0, 64'h8, "R7");
        chk_irq(1'b0, "R8");
        wr(12'hC40, 64'h8);
        chk_irq(1'b1, "R8");
        wr(12'hE50, 64'h0);
        chk_irq(1'b0, "R8");

        // R9 write beats a same-cycle increment of the cycle counter
        wr(12'h008, 64'h100);
        chk_val(12'h008, 64'h100, "R9");
        chk_model(12'h008, "R9");

        repeat (3) @(negedge clk);
        chk_model(12'h008, "R3");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule